// File: doc/BRIEF.md
# Color Subcarrier and Burst Generator

This block supplies the chroma path of a composite/S-video encoder with its color reference. Running at the 27 MHz DAC sample rate, a 32-bit phase accumulator advances by a mode-dependent increment. The phase feeds a quarter-wave sine table that yields signed quadrature samples: a U carrier (sine) and a V carrier (cosine). A downstream modulator multiplies these with the color-difference data.

The block also produces a gated burst sample and a burst-active flag. The burst opens a fixed number of clocks after each line start and lasts for the number of subcarrier cycles set by the standard. It is skipped on the vertical sync and equalizing lines. In the PAL standards the V carrier changes sign every other line. On those same lines the burst angle swaps between 135° and 225° relative to U. Line start, line number and field come from the sync generator. A fixed reference line restarts the phase so that burst phase repeats over the color-field sequence.

Top module: `chroma_subcarrier_gen`

## Requirements
- R1: While reset is asserted, all sample outputs are zero and the burst flag is low. Reset also clears the accumulator to zero, the line switch to 0 and the line position to its saturated value.
- R2: Mode encoding is 2'b11 = NTSC (525 lines), 2'b10 = PAL (625 lines), 2'b01 = PAL-60 (525 lines), 2'b00 = sleep. In the non-sleep modes the 32-bit phase advances every clock, by 569408543 for NTSC and by 705268427 for PAL and PAL-60.
- R3: wave(p) works as follows. Bits [31:30] of p are the quadrant q and bits [29:24] are an index a. Let k = a for even q and k = 63-a for odd q. The magnitude is round(255*sin((k+0.5)*pi/128)), and the value is negative for q >= 2. One clock after the phase p is held, sin_o = wave(p) and cos_o = wave(p + 2^30), the latter before the PAL sign rule of R8.
- R4: A line start with line number 1 and field 0 is the reference line start. It sets the phase to zero at the clock edge that samples it.
- R5: The burst flag is high for exactly round(cycles*2^32/increment) clocks. That is 68 clocks for NTSC (9 cycles) and 61 clocks for PAL and PAL-60 (10 cycles). The first high sample comes BURST_START+1 clocks after the edge that samples line_start.
- R6: In NTSC the burst sample is wave(p + 2^31), which is the negation of sin_o. Outside the burst flag the burst sample is zero.
- R7: No burst is produced on quiet lines. In 525-line modes these are lines 1-9 and 264-272. In PAL they are lines 1-5, 311-318 and 623-625.
- R8: In PAL and PAL-60, cos_o is negated on lines where the switch is 1.
- R9: In PAL and PAL-60 the burst sample is wave(p + 3*2^29) (135°) when the switch is 0, and wave(p + 5*2^29) (225°) when the switch is 1.
- R10: The switch inverts at every line start, except that the reference line start clears it to 0.
- R11: In sleep mode the sample outputs are zero and the flag stays low. The phase holds its value and resumes from it when a non-sleep mode returns.
- R12: PAL-60 uses the PAL increment, burst angles and length together with the 525-line quiet lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Standard select (R2 encoding) |
| line_start | input | 1 | One-clock pulse at the start of each line |
| line_num | input | LINE_W | Line number of the starting line, from 1 |
| field | input | 2 | Field index in the four-field sequence |
| sin_o | output | SAMP_W | Signed U-carrier sample |
| cos_o | output | SAMP_W | Signed V-carrier sample, sign-switched in PAL |
| burst_o | output | SAMP_W | Signed burst sample, zero outside the burst |
| burst_active_o | output | 1 | High while the burst is being sent |

## Verification
The bench builds the block with BURST_START reduced to 16 and every other parameter at its default: the 32-bit accumulator, the 64-entry quarter table, 9-bit samples and the real increments. The short porch delay lets each test line finish in about a hundred clocks. That makes room to visit the reference line, the quiet-line edges of both line counts, and several PAL switch alternations. Because the increments are the real ones, the measured burst lengths of 68 and 61 clocks and the sample values follow the true NTSC and PAL phase trajectories.

// File: rtl/chroma_subcarrier_gen.sv
module chroma_subcarrier_gen #(
  parameter int ACC_W = 32,
  parameter int SAMP_W = 9,
  parameter int LUT_AW = 6,
  parameter int LINE_W = 10,
  parameter int POS_W = 9,
  parameter logic [ACC_W-1:0] INC_NTSC = 32'd569408543,
  parameter logic [ACC_W-1:0] INC_PAL = 32'd705268427,
  parameter int CYC_NTSC = 9,
  parameter int CYC_PAL = 10,
  parameter int BURST_START = 143,
  parameter int REF_LINE = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode,
  input  logic                     line_start,
  input  logic [LINE_W-1:0]        line_num,
  input  logic [1:0]               field,
  output logic signed [SAMP_W-1:0] sin_o,
  output logic signed [SAMP_W-1:0] cos_o,
  output logic signed [SAMP_W-1:0] burst_o,
  output logic                     burst_active_o
);

  localparam int LUT_N = 1 << LUT_AW;
  localparam int AMP = (1 << (SAMP_W - 1)) - 1;
  localparam longint unsigned SCALE = 64'd1 << ACC_W;
  localparam int LEN_NTSC = int'((longint'(CYC_NTSC) * SCALE + longint'(INC_NTSC) / 2) / longint'(INC_NTSC));
  localparam int LEN_PAL = int'((longint'(CYC_PAL) * SCALE + longint'(INC_PAL) / 2) / longint'(INC_PAL));
  localparam logic [1:0] M_SLEEP = 2'b00;
  localparam logic [1:0] M_P60 = 2'b01;
  localparam logic [1:0] M_PAL = 2'b10;
  localparam logic [1:0] M_NTSC = 2'b11;
  localparam logic [ACC_W-1:0] OFF_90 = ACC_W'(1) << (ACC_W - 2);
  localparam logic [ACC_W-1:0] OFF_180 = ACC_W'(1) << (ACC_W - 1);
  localparam logic [ACC_W-1:0] OFF_135 = ACC_W'(3) << (ACC_W - 3);
  localparam logic [ACC_W-1:0] OFF_225 = ACC_W'(5) << (ACC_W - 3);
  localparam logic [POS_W-1:0] WIN_LO = POS_W'(BURST_START);
  localparam logic [POS_W-1:0] WIN_HI_NTSC = POS_W'(BURST_START + LEN_NTSC);
  localparam logic [POS_W-1:0] WIN_HI_PAL = POS_W'(BURST_START + LEN_PAL);

  logic [SAMP_W-2:0] lut [LUT_N];

  for (genvar gi = 0; gi < LUT_N; gi++) begin : g_lut
    localparam real ANG = (real'(gi) + 0.5) * 3.14159265358979 / (2.0 * real'(LUT_N));
    assign lut[gi] = (SAMP_W - 1)'($rtoi(real'(AMP) * $sin(ANG) + 0.5));
  end

  function automatic logic signed [SAMP_W-1:0] wave(input logic [ACC_W-1:0] ph);
    logic [1:0] quad;
    logic [LUT_AW-1:0] addr;
    logic signed [SAMP_W-1:0] mag;
    quad = ph[ACC_W-1 -: 2];
    addr = ph[ACC_W-3 -: LUT_AW];
    if (quad[0]) addr = ~addr;
    mag = $signed({1'b0, lut[addr]});
    return quad[1] ? -mag : mag;
  endfunction

  function automatic logic quiet_line(input logic [LINE_W-1:0] ln, input logic is525);
    if (is525)
      return (ln >= LINE_W'(1) && ln <= LINE_W'(9)) || (ln >= LINE_W'(264) && ln <= LINE_W'(272));
    return (ln >= LINE_W'(1) && ln <= LINE_W'(5)) || (ln >= LINE_W'(311) && ln <= LINE_W'(318)) ||
           (ln >= LINE_W'(623) && ln <= LINE_W'(625));
  endfunction

  logic [ACC_W-1:0]  acc;
  logic              sw;
  logic [POS_W-1:0]  pos;
  logic [LINE_W-1:0] line_q;

  wire ref_hit = line_start && line_num == LINE_W'(REF_LINE) && field == 2'd0;
  wire active = mode != M_SLEEP;
  wire pal = mode == M_PAL || mode == M_P60;
  wire [ACC_W-1:0] inc = pal ? INC_PAL : INC_NTSC;
  wire [POS_W-1:0] win_hi = pal ? WIN_HI_PAL : WIN_HI_NTSC;
  wire in_win = pos >= WIN_LO && pos < win_hi;
  wire flag_d = active && !quiet_line(line_q, mode != M_PAL) && in_win;
  wire [ACC_W-1:0] boff = !pal ? OFF_180 : (sw ? OFF_225 : OFF_135);
  wire signed [SAMP_W-1:0] cos_raw = wave(acc + OFF_90);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      sw <= 1'b0;
      pos <= '1;
      line_q <= '0;
      sin_o <= '0;
      cos_o <= '0;
      burst_o <= '0;
      burst_active_o <= 1'b0;
    end else begin
      if (ref_hit) acc <= '0;
      else if (active) acc <= acc + inc;
      if (line_start) begin
        sw <= ref_hit ? 1'b0 : ~sw;
        pos <= '0;
        line_q <= line_num;
      end else if (pos != '1) begin
        pos <= pos + 1'b1;
      end
      sin_o <= active ? wave(acc) : '0;
      cos_o <= !active ? '0 : (pal && sw) ? -cos_raw : cos_raw;
      burst_active_o <= flag_d;
      burst_o <= flag_d ? wave(acc + boff) : '0;
    end
  end

  a_r4_ref_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ref_hit |=> acc == '0);

  a_r10_switch_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (line_start && !ref_hit) |=> sw != $past(sw));

  a_r11_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP && !ref_hit) |=> $stable(acc));

  a_r11_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_SLEEP) |=> (sin_o == '0 && cos_o == '0 && !burst_active_o));

  a_r6_ntsc_burst_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active_o && $past(mode) == M_NTSC) |-> burst_o == -sin_o);

endmodule

// File: tb/chroma_subcarrier_gen_tb.sv
module chroma_subcarrier_gen_tb_top;
  localparam int START = 16;
  localparam logic [31:0] INC_N = 32'd569408543;
  localparam logic [31:0] INC_P = 32'd705268427;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] mode = 2'b11;
  logic line_start = 0;
  logic [9:0] line_num = 10'd100;
  logic [1:0] field = 2'd1;
  logic signed [8:0] sin_o, cos_o, burst_o;
  logic burst_active_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] acc_m = 0;
  logic sw_m = 0;
  int pos_m = 511;
  int lineq_m = 0;
  logic [31:0] last_phase;
  logic last_sw;
  int e_sin, e_cos, e_burst;
  bit e_flag;

  always #10 clk = ~clk;

  chroma_subcarrier_gen #(.BURST_START(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_start(line_start),
    .line_num(line_num), .field(field), .sin_o(sin_o), .cos_o(cos_o),
    .burst_o(burst_o), .burst_active_o(burst_active_o)
  );

  function automatic int exp_wave(input logic [31:0] ph);
    int q, a, k, m;
    q = int'(ph[31:30]);
    a = int'(ph[29:24]);
    k = (q % 2 == 1) ? 63 - a : a;
    m = $rtoi(255.0 * $sin((real'(k) + 0.5) * 3.14159265358979 / 128.0) + 0.5);
    return (q >= 2) ? -m : m;
  endfunction

  function automatic bit quiet(input int ln, input logic [1:0] md);
    if (md != 2'b10) return (ln >= 1 && ln <= 9) || (ln >= 264 && ln <= 272);
    return (ln >= 1 && ln <= 5) || (ln >= 311 && ln <= 318) || (ln >= 623 && ln <= 625);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    bit act, pal, refh;
    int len;
    logic [31:0] off;
    @(posedge clk);
    act = mode != 2'b00;
    pal = mode == 2'b10 || mode == 2'b01;
    len = pal ? 61 : 68;
    last_phase = acc_m;
    last_sw = sw_m;
    e_sin = act ? exp_wave(acc_m) : 0;
    e_cos = !act ? 0 : ((pal && sw_m) ? -exp_wave(acc_m + 32'h4000_0000) : exp_wave(acc_m + 32'h4000_0000));
    e_flag = act && !quiet(lineq_m, mode) && pos_m >= START && pos_m < START + len;
    off = !pal ? 32'h8000_0000 : (sw_m ? 32'hA000_0000 : 32'h6000_0000);
    e_burst = e_flag ? exp_wave(acc_m + off) : 0;
    refh = line_start && line_num == 10'd1 && field == 2'd0;
    if (refh) acc_m = 0;
    else if (act) acc_m = acc_m + (pal ? INC_P : INC_N);
    if (line_start) begin
      sw_m = refh ? 1'b0 : ~sw_m;
      pos_m = 0;
      lineq_m = int'(line_num);
    end else if (pos_m < 511) pos_m++;
    @(negedge clk);
    check(int'(sin_o) == e_sin, "R3 sin", int'(sin_o), e_sin);
    check(int'(cos_o) == e_cos, "R8 cos", int'(cos_o), e_cos);
    check(burst_active_o == e_flag, "R5 flag", int'(burst_active_o), int'(e_flag));
    check(int'(burst_o) == e_burst, "R6 burst", int'(burst_o), e_burst);
  endtask

  task automatic pulse(input int ln, input int fd);
    line_num = 10'(ln);
    field = 2'(fd);
    line_start = 1;
    step();
    line_start = 0;
    line_num = 10'd100;
    field = 2'd1;
  endtask

  task automatic run_line(input int ln, input int fd, output int first, output int len);
    first = -1;
    len = 0;
    pulse(ln, fd);
    for (int j = 1; j <= START + 80; j++) begin
      step();
      if (burst_active_o) begin
        if (first < 0) first = j;
        len++;
      end
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(sin_o == 0 && cos_o == 0, "R1 samples zero", int'(sin_o), 0);
    check(burst_o == 0, "R1 burst zero", int'(burst_o), 0);
    check(!burst_active_o, "R1 flag low", int'(burst_active_o), 0);
    rst_n = 1;
  endtask

  task automatic t_ntsc();
    int f, l;
    mode = 2'b11;
    repeat (40) step();
    pulse(1, 0);
    step();
    check(int'(sin_o) == 3, "R4 phase zero sin", int'(sin_o), 3);
    check(int'(cos_o) == 255, "R3 cos peak at phase zero", int'(cos_o), 255);
    step();
    check(int'(sin_o) == exp_wave(INC_N), "R2 ntsc increment", int'(sin_o), exp_wave(INC_N));
    run_line(20, 0, f, l);
    check(f == START + 1, "R5 ntsc burst start", f, START + 1);
    check(l == 68, "R5 ntsc burst length", l, 68);
    pulse(21, 0);
    for (int j = 0; j < START + 40; j++) begin
      step();
      if (burst_active_o) check(burst_o == -sin_o, "R6 ntsc burst opposite U", int'(burst_o), -int'(sin_o));
    end
  endtask

  task automatic t_quiet();
    int f, l;
    mode = 2'b11;
    run_line(5, 1, f, l);   check(l == 0, "R7 ntsc line 5", l, 0);
    run_line(266, 1, f, l); check(l == 0, "R7 ntsc line 266", l, 0);
    run_line(10, 1, f, l);  check(l == 68, "R7 ntsc line 10", l, 68);
    mode = 2'b10;
    run_line(3, 1, f, l);   check(l == 0, "R7 pal line 3", l, 0);
    run_line(315, 1, f, l); check(l == 0, "R7 pal line 315", l, 0);
    run_line(624, 1, f, l); check(l == 0, "R7 pal line 624", l, 0);
    run_line(319, 1, f, l); check(l == 61, "R7 pal line 319", l, 61);
  endtask

  task automatic t_pal();
    int f, l;
    mode = 2'b10;
    pulse(1, 0);
    step();
    check(int'(cos_o) == exp_wave(last_phase + 32'h4000_0000), "R10 switch cleared, V positive",
          int'(cos_o), exp_wave(last_phase + 32'h4000_0000));
    pulse(40, 0);
    for (int j = 1; j <= START + 70; j++) begin
      step();
      if (j == 3) check(int'(cos_o) == -exp_wave(last_phase + 32'h4000_0000), "R8 V negated",
                        int'(cos_o), -exp_wave(last_phase + 32'h4000_0000));
      if (burst_active_o) check(int'(burst_o) == exp_wave(last_phase + 32'hA000_0000), "R9 burst 225",
                                int'(burst_o), exp_wave(last_phase + 32'hA000_0000));
    end
    pulse(41, 0);
    for (int j = 1; j <= START + 70; j++) begin
      step();
      if (j == 3) check(int'(cos_o) == exp_wave(last_phase + 32'h4000_0000), "R10 switch toggled back",
                        int'(cos_o), exp_wave(last_phase + 32'h4000_0000));
      if (burst_active_o) check(int'(burst_o) == exp_wave(last_phase + 32'h6000_0000), "R9 burst 135",
                                int'(burst_o), exp_wave(last_phase + 32'h6000_0000));
    end
    run_line(42, 0, f, l);
    check(f == START + 1 && l == 61, "R5 pal burst length", l, 61);
  endtask

  task automatic t_sleep();
    int f, l;
    logic [31:0] held;
    mode = 2'b11;
    repeat (7) step();
    mode = 2'b00;
    step();
    held = acc_m;
    run_line(20, 0, f, l);
    check(l == 0, "R11 no burst in sleep", l, 0);
    check(sin_o == 0 && cos_o == 0, "R11 samples zero", int'(sin_o), 0);
    mode = 2'b11;
    step();
    check(int'(sin_o) == exp_wave(held), "R11 phase held", int'(sin_o), exp_wave(held));
  endtask

  task automatic t_pal60();
    int f, l;
    mode = 2'b01;
    run_line(266, 1, f, l); check(l == 0, "R12 pal60 line 266 quiet", l, 0);
    run_line(8, 1, f, l);   check(l == 0, "R12 pal60 line 8 quiet", l, 0);
    run_line(315, 1, f, l); check(l == 61, "R12 pal60 line 315 burst", l, 61);
    step();
    check(int'(sin_o) == exp_wave(last_phase), "R12 pal60 increment", int'(sin_o), exp_wave(last_phase));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_ntsc();
    t_quiet();
    t_pal();
    t_sleep();
    t_pal60();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule